// File: doc/BRIEF.md
# Snoop Retry Response Generator

This block sits beside a cache's snoop port on a shared address bus. When another master starts an address tenure, the block waits for the snoop lookup result. If the lookup shows a hit on dirty data, or the snoop logic is stalled and cannot service the transfer, the block drives an address-retry response. It starts the response at the earliest legal cycle and holds it through the cycle that qualifies the retry.

After a qualified retry caused by a dirty hit, the block raises its own bus request in the very next cycle. In that cycle no other master is allowed to request, so this master wins the bus for its copy-back. The block may take several cycles to prepare the push, so it does not accept a grant until that preparation window has passed. Once it accepts the grant, it drives its own transfer start, drops the request and pulses push-start to the copy-back engine. The cache array, the tag lookup and the data movement are outside this block. All pins are plain control signals. No data flows through the block, so there is no valid/ready interface and no back-pressure.

Top module: `snoop_retry_gen`

## Requirements
- R1: With reset low, `retry_o` stays low unless a transfer start was accepted and the lookup reported dirty or stall. A transfer start presented while `rst_n` is low is ignored.
- R2: A dirty hit (`hit_dirty_i`=1) in the lookup cycle produces a retry and a later copy-back request.
- R3: A stall (`snoop_stall_i`=1) with no dirty hit produces a retry, and `req_o` stays low.
- R4: The lookup result is sampled in the cycle after the transfer-start cycle (for `LOOKUP_LAT`=1). `retry_o` first goes high in the second cycle after the transfer-start cycle.
- R5: Once high, `retry_o` stays high through the cycle after `addr_ack_i` is seen and falls in the cycle after that. `addr_ack_i` must come at least one cycle after the transfer start.
- R6: If the retry was caused by a dirty hit, `req_o` rises in the cycle right after the qualified-retry cycle.
- R7: `req_o` stays high until the grant is accepted. The grant is accepted in the first cycle, no earlier than `PREP_CYCLES` cycles after `req_o` rose, in which `grant_i` is high.
- R8: In the cycle after the grant is accepted, `req_o` is low and `own_start_o` and `push_start_o` are each high for exactly one cycle.
- R9: A transfer start is ignored while a tenure is still being handled, and while the block's own copy-back request is pending.
- R10: After reset, `retry_o`, `req_o`, `own_start_o` and `push_start_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start_i | input | 1 | Another master's transfer start |
| addr_ack_i | input | 1 | Address acknowledge for the current tenure |
| hit_dirty_i | input | 1 | Lookup result: hit on modified data |
| snoop_stall_i | input | 1 | Lookup result: snoop cannot be serviced |
| grant_i | input | 1 | Bus grant to this master |
| retry_o | output | 1 | Address-retry response |
| req_o | output | 1 | Bus request for the copy-back |
| own_start_o | output | 1 | This master's transfer start for the push |
| push_start_o | output | 1 | One-cycle pulse to the copy-back engine |

## Verification
The bound checker watches several timing rules on every cycle:
- the retry never rises without a lookup cause, nor directly after a transfer start;
- the retry is held across and released after the acknowledge;
- the request rises only after a retry ends;
- the request never drops while the grant is absent;
- the push-start is a single pulse that follows an accepted grant.

Other behaviours need the bench's scenarios, because they depend on the exact cycle arithmetic:
- the stall-only retry that never requests;
- grants arriving before or after the preparation window;
- transfer starts ignored during reset and while a copy-back is pending.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_LOOK = 2'd1,
    W_HOLD = 2'd2,
    W_QUAL = 2'd3
  } win_state_t;
endpackage

// File: rtl/srr_window.sv
module srr_window
  import srr_pkg::*;
#(
  parameter int LOOKUP_LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start_i,
  input  logic addr_ack_i,
  input  logic hit_dirty_i,
  input  logic snoop_stall_i,
  input  logic push_busy_i,
  output logic retry_o,
  output logic cb_req_o
);
  localparam int LAT_W = (LOOKUP_LAT < 2) ? 1 : $clog2(LOOKUP_LAT);

  win_state_t       st;
  logic [LAT_W-1:0] lat_cnt;
  logic             ack_seen;
  logic             retry_q;
  logic             dirty_q;
  logic             ack_now;

  assign ack_now = ack_seen | addr_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      lat_cnt  <= '0;
      ack_seen <= 1'b0;
      retry_q  <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      case (st)
        W_IDLE: begin
          if (xfer_start_i && !push_busy_i) begin
            st       <= W_LOOK;
            lat_cnt  <= LAT_W'(LOOKUP_LAT - 1);
            ack_seen <= 1'b0;
          end
        end
        W_LOOK: begin
          if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt - 1'b1;
            if (addr_ack_i) ack_seen <= 1'b1;
          end else if (hit_dirty_i || snoop_stall_i) begin
            retry_q <= 1'b1;
            dirty_q <= hit_dirty_i;
            st      <= ack_now ? W_QUAL : W_HOLD;
          end else begin
            dirty_q <= 1'b0;
            st      <= ack_now ? W_IDLE : W_HOLD;
          end
        end
        W_HOLD: begin
          if (addr_ack_i) st <= retry_q ? W_QUAL : W_IDLE;
        end
        W_QUAL: begin
          retry_q <= 1'b0;
          dirty_q <= 1'b0;
          st      <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign retry_o  = retry_q;
  assign cb_req_o = (st == W_QUAL) && dirty_q;
endmodule

// File: rtl/srr_push.sv
module srr_push #(
  parameter int PREP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cb_req_i,
  input  logic grant_i,
  output logic req_o,
  output logic start_o,
  output logic busy_o
);
  localparam int PW = (PREP_CYCLES < 2) ? 1 : $clog2(PREP_CYCLES + 1);

  logic          req_q;
  logic          start_q;
  logic [PW-1:0] prep_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      start_q  <= 1'b0;
      prep_cnt <= '0;
    end else begin
      start_q <= 1'b0;
      if (cb_req_i) begin
        req_q    <= 1'b1;
        prep_cnt <= PW'(PREP_CYCLES);
      end else if (req_q) begin
        if (prep_cnt != '0) begin
          prep_cnt <= prep_cnt - 1'b1;
        end else if (grant_i) begin
          req_q   <= 1'b0;
          start_q <= 1'b1;
        end
      end
    end
  end

  assign req_o   = req_q;
  assign start_o = start_q;
  assign busy_o  = req_q;
endmodule

// File: rtl/snoop_retry_gen.sv
module snoop_retry_gen #(
  parameter int LOOKUP_LAT  = 1,
  parameter int PREP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start_i,
  input  logic addr_ack_i,
  input  logic hit_dirty_i,
  input  logic snoop_stall_i,
  input  logic grant_i,
  output logic retry_o,
  output logic req_o,
  output logic own_start_o,
  output logic push_start_o
);
  logic cb_req;
  logic push_busy;
  logic start_pulse;

  srr_window #(.LOOKUP_LAT(LOOKUP_LAT)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_start_i (xfer_start_i),
    .addr_ack_i   (addr_ack_i),
    .hit_dirty_i  (hit_dirty_i),
    .snoop_stall_i(snoop_stall_i),
    .push_busy_i  (push_busy),
    .retry_o      (retry_o),
    .cb_req_o     (cb_req)
  );

  srr_push #(.PREP_CYCLES(PREP_CYCLES)) u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .cb_req_i(cb_req),
    .grant_i (grant_i),
    .req_o   (req_o),
    .start_o (start_pulse),
    .busy_o  (push_busy)
  );

  assign own_start_o  = start_pulse;
  assign push_start_o = start_pulse;
endmodule

// File: rtl/snoop_retry_gen_chk.sv
module snoop_retry_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_start_i,
  input logic addr_ack_i,
  input logic hit_dirty_i,
  input logic snoop_stall_i,
  input logic grant_i,
  input logic retry_o,
  input logic req_o,
  input logic own_start_o,
  input logic push_start_o
);
  // R2
  retry_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_o) |-> $past(hit_dirty_i || snoop_stall_i));
  // R4
  retry_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_o) |-> !$past(xfer_start_i));
  // R5
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o && addr_ack_i |=> retry_o);
  // R5
  retry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retry_o) |-> $past(addr_ack_i, 2));
  // R6
  req_after_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ($past(retry_o) && !retry_o));
  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !grant_i |=> req_o);
  // R8
  push_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_start_o |-> (!req_o && $past(req_o && grant_i)));
  // R8
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_start_o |=> !push_start_o);
  // R8
  own_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_start_o |=> !own_start_o);
endmodule

bind snoop_retry_gen snoop_retry_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xfer_start_i (xfer_start_i),
  .addr_ack_i   (addr_ack_i),
  .hit_dirty_i  (hit_dirty_i),
  .snoop_stall_i(snoop_stall_i),
  .grant_i      (grant_i),
  .retry_o      (retry_o),
  .req_o        (req_o),
  .own_start_o  (own_start_o),
  .push_start_o (push_start_o)
);

// File: tb/snoop_retry_gen_test.sv
`timescale 1ns/100ps
module snoop_retry_gen_test;
  localparam int PREP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xs = 1'b0, ack = 1'b0, hd = 1'b0, st = 1'b0, gr = 1'b0;
  logic retry, req, own, push;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  art;
    logic  rq;
    logic  ps;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  snoop_retry_gen #(.LOOKUP_LAT(1), .PREP_CYCLES(PREP)) uut (
    .clk(clk), .rst_n(rst_n), .xfer_start_i(xs), .addr_ack_i(ack),
    .hit_dirty_i(hd), .snoop_stall_i(st), .grant_i(gr),
    .retry_o(retry), .req_o(req), .own_start_o(own), .push_start_o(push)
  );

  // monitor: pops one expectation per cycle after the edge
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (retry !== e.art || req !== e.rq || push !== e.ps || own !== e.ps) begin
        fails++;
        $display("FAIL %s: got retry=%b req=%b push=%b own=%b expected retry=%b req=%b push=%b",
                 e.tag, retry, req, push, own, e.art, e.rq, e.ps);
      end
    end
  end

  task automatic step(input logic s, a, h, k, g, input logic ea, er, ep, input string tag);
    exp_t e;
    @(negedge clk);
    xs = s; ack = a; hd = h; st = k; gr = g;
    e.art = ea; e.rq = er; e.ps = ep; e.tag = tag;
    sb.push_back(e);
  endtask

  // ts in cycle 0, lookup in cycle 1, ack in cycle A, grant from cycle G
  task automatic scenario(input bit hit, input bit stall, input int A, input int G,
                          input bit extra_ts, input string tag);
    bit rt;
    int q_c, rq_c, g_c, n;
    rt   = hit || stall;
    q_c  = (A + 1 > 2) ? A + 1 : 2;
    rq_c = q_c + 1;
    g_c  = (rq_c + PREP > G) ? rq_c + PREP : G;
    n    = hit ? g_c + 4 : q_c + 4;
    for (int c = 0; c <= n; c++) begin
      int k;
      logic s, h;
      k = c + 1;
      s = (c == 0) || (extra_ts && hit && c == rq_c + 1);
      h = (hit && c == 1) || (extra_ts && hit && c == rq_c + 2);
      step(s, c == A, h, stall && c == 1, hit && c >= G && c <= g_c,
           rt && k >= 2 && k <= q_c,
           hit && k >= rq_c && k <= g_c,
           hit && k == g_c + 1, tag);
    end
    repeat (2) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    // R1: transfer start during reset
    repeat (2) @(negedge clk);
    xs = 1'b1; hd = 1'b1;
    @(negedge clk);
    rst_n = 1'b1; xs = 1'b0; hd = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (retry !== 1'b0 || req !== 1'b0 || own !== 1'b0 || push !== 1'b0) begin
      fails++;
      $display("FAIL R10: got retry=%b req=%b own=%b push=%b expected all 0",
               retry, req, own, push);
    end
    repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset start ignored");
    // R1: lookup flags without any transfer start
    step(0, 0, 1, 1, 0, 0, 0, 0, "R1 no start");
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, "R1 no start");
    // R1: start with clean lookup
    scenario(0, 0, 3, 0, 0, "R1 clean lookup");
    // R2 R4 R5 R6 R7 R8: dirty hit, late ack, grant already high
    scenario(1, 0, 4, 0, 0, "R2 R4 R5 R6 R7 R8 dirty late ack");
    // R4 R5: ack in cycle after start, qualified at earliest
    scenario(1, 0, 1, 0, 0, "R4 R5 R6 dirty early ack");
    // R3: stall only
    scenario(0, 1, 2, 0, 0, "R3 stall only");
    // R2 R3: both flags
    scenario(1, 1, 3, 0, 0, "R2 R3 both flags");
    // R7: grant late
    scenario(1, 0, 2, 12, 0, "R7 late grant");
    // R9: start while request pending is ignored
    scenario(1, 0, 2, 14, 1, "R9 start during pending push");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule